// File: doc/BRIEF.md
# Compare/Capture Timer-Counter

This peripheral holds one up-counter whose width is picked at run time, fed either by a prescaled tick derived from the block clock (timer mode) or by software increment tasks (counter mode). Four channels each keep a compare value that can also act as a capture register. When the counter reaches a channel's value, the channel's sticky event flag is raised. Per-channel link bits can make that match zero the counter or halt it.

Software drives the block through a word-addressed register port. A write of the value 1 to a task address triggers the task. Events are acknowledged by writing 0 to them. Read data shows up one cycle after the address. A single level interrupt is raised while any enabled event is pending.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, every event, every compare value, the link bits, the interrupt enables, the mode, the width code and the prescaler are zero, the counter is halted and `irq` is low.
- R2: The width code (register 0x74, bits 1:0) selects 16 bits for 0, 8 bits for 1, 24 bits for 2 and 32 bits for 3. Every increment wraps the counter modulo 2^width.
- R3: In timer mode (register 0x70 bit 0 = 0), a running counter advances once every 2^P clock cycles, where P is the prescaler (register 0x78). The divider restarts on START and on CLEAR. A written prescaler above 9 is stored as 9.
- R4: Event i (register 0x40+4i, bit 0) is set when an increment makes the counter equal compare value i, including after a wrap. Writing 0 clears the event. Writing any other value leaves it unchanged.
- R5: Link register (0x60) bit i (bits 0-3) makes a channel-i match put the counter at 0 instead of the matched value.
- R6: Link register bit 8+i (bits 8-11) makes a channel-i match halt the counter.
- R7: `irq` is high exactly when some event i is set and its enable bit 16+i is set.
- R8: A write to 0x64 sets the enable bits given in write-data bits 16-19. A write to 0x68 clears them. Both addresses read back the enable set in bits 16-19, and all other bits read as zero.
- R9: A task acts only when the written value is exactly 1. START (0x00) runs the counter only in timer mode. COUNT (0x08, counter mode only, register 0x70 bit 0 = 1) adds one and checks matches. STOP (0x04) and SHUTDOWN (0x10) halt counting.
- R10: CLEAR (0x0C) sets the counter to 0. CAPTURE i (0x20+4i) copies the counter into compare value i (read at 0x80+4i).
- R11: A value written to compare register 0x80+4i is truncated to the width selected at the time of the write.
- R12: Read data for an address appears on `rdata` one cycle later. Undefined addresses and task addresses read as zero, and writes to undefined addresses change nothing.
- R13: When a capture or an event-clear write lands in the same cycle as a tick, the capture stores the counter value after that tick, and a match made by the tick leaves the event set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the access; bits 1:0 ignored |
| wen | input | 1 | Write strobe for this cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt: any enabled event pending |

## Verification
Two things can fall in the same clock edge: a prescaler tick, and a software write that observes or edits the state that tick changes. The bench runs the counter at prescaler 0 from a known START edge. It then times a capture write, and separately a write of 0 to an event, onto exactly the edge where the counter steps to a predicted value. The capture must hold the post-tick count, and the event whose compare value equals that count must still read as set. A later write of 0 must then clear it.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int ADDR_W    = 8,
  parameter int PRESC_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int NCH   = 4;
  localparam int DIV_W = PRESC_MAX + 1;
  localparam int WIX_W = ADDR_W - 2;
  localparam int K_START = 0, K_STOP = 1, K_COUNT = 2, K_CLEAR = 3, K_HALT = 4;
  localparam int K_CAP = 8, K_EVT = 16, K_LINK = 24, K_IENS = 25, K_IENC = 26;
  localparam int K_MODE = 28, K_WIDTH = 29, K_PRESC = 30, K_CMP = 32;

  logic [WIX_W-1:0] wix;
  logic [31:0] cnt, cnt_nxt, mask, inc_val;
  logic [31:0] cc [NCH];
  logic [NCH-1:0] evt, ien, sh_clr, sh_stop, hit, evt_clr, cap, cc_wr;
  logic running, mode, trig, tick, inc;
  logic wr_start, wr_stop, wr_count, wr_clear;
  logic [1:0] wsel;
  logic [3:0] presc;
  logic [DIV_W-1:0] div, div_top;
  logic [31:0] rd_nxt;

  assign wix  = addr[ADDR_W-1:2];
  assign trig = wen && (wdata == 32'd1);

  assign wr_start = trig && !mode && (wix == WIX_W'(K_START));
  assign wr_stop  = trig && ((wix == WIX_W'(K_STOP)) || (wix == WIX_W'(K_HALT)));
  assign wr_count = trig && mode && (wix == WIX_W'(K_COUNT));
  assign wr_clear = trig && (wix == WIX_W'(K_CLEAR));

  always_comb begin
    case (wsel)
      2'd0:    mask = 32'h0000_FFFF;
      2'd1:    mask = 32'h0000_00FF;
      2'd2:    mask = 32'h00FF_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  assign div_top = (DIV_W'(1) << presc) - DIV_W'(1);
  assign tick    = running && !mode && (div == div_top);
  assign inc     = (tick && !wr_clear) || wr_count;
  assign inc_val = (cnt + 32'd1) & mask;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign hit[g]     = inc && (inc_val == cc[g]);
      assign evt_clr[g] = wen && (wdata == 32'd0) && (wix == WIX_W'(K_EVT + g));
      assign cap[g]     = trig && (wix == WIX_W'(K_CAP + g));
      assign cc_wr[g]   = wen && (wix == WIX_W'(K_CMP + g));

      always_ff @(posedge clk) begin
        if (!rst_n)          cc[g] <= '0;
        else if (cap[g])     cc[g] <= cnt_nxt;
        else if (cc_wr[g])   cc[g] <= wdata & mask;
      end
    end
  endgenerate

  always_comb begin
    cnt_nxt = cnt;
    if (wr_clear)                 cnt_nxt = '0;
    else if (inc)                 cnt_nxt = (|(hit & sh_clr)) ? '0 : inc_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      evt     <= '0;
      ien     <= '0;
      sh_clr  <= '0;
      sh_stop <= '0;
      running <= 1'b0;
      mode    <= 1'b0;
      wsel    <= '0;
      presc   <= '0;
      div     <= '0;
    end else begin
      cnt <= cnt_nxt;
      evt <= (evt & ~evt_clr) | hit;

      if (wr_start)                          running <= 1'b1;
      else if (wr_stop || |(hit & sh_stop))  running <= 1'b0;

      if (wr_start || wr_clear)   div <= '0;
      else if (running && !mode)  div <= tick ? '0 : div + DIV_W'(1);

      if (wen) begin
        if (wix == WIX_W'(K_LINK)) begin
          sh_clr  <= wdata[3:0];
          sh_stop <= wdata[11:8];
        end
        if (wix == WIX_W'(K_IENS))  ien <= ien | wdata[19:16];
        if (wix == WIX_W'(K_IENC))  ien <= ien & ~wdata[19:16];
        if (wix == WIX_W'(K_MODE))  mode <= wdata[0];
        if (wix == WIX_W'(K_WIDTH)) wsel <= wdata[1:0];
        if (wix == WIX_W'(K_PRESC))
          presc <= (wdata > 32'(PRESC_MAX)) ? 4'(PRESC_MAX) : wdata[3:0];
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (wix == WIX_W'(K_LINK))                               rd_nxt = {20'd0, sh_stop, 4'd0, sh_clr};
    if ((wix == WIX_W'(K_IENS)) || (wix == WIX_W'(K_IENC)))  rd_nxt = {12'd0, ien, 16'd0};
    if (wix == WIX_W'(K_MODE))                               rd_nxt = {31'd0, mode};
    if (wix == WIX_W'(K_WIDTH))                              rd_nxt = {30'd0, wsel};
    if (wix == WIX_W'(K_PRESC))                              rd_nxt = {28'd0, presc};
    for (int i = 0; i < NCH; i++) begin
      if (wix == WIX_W'(K_EVT + i)) rd_nxt = {31'd0, evt[i]};
      if (wix == WIX_W'(K_CMP + i)) rd_nxt = cc[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_nxt;
  end

  assign irq = |(evt & ien);
endmodule

module cmp_timer_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wen,
  input logic [31:0]       wdata,
  input logic              irq,
  input logic [31:0]       cnt,
  input logic              running,
  input logic              mode,
  input logic [3:0]        evt,
  input logic [3:0]        ien,
  input logic [3:0]        presc,
  input logic              tick
);
  logic [ADDR_W-3:0] w;
  assign w = addr[ADDR_W-1:2];

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((evt & ien) != 4'd0));

  p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wdata == 32'd1 && (w == 1 || w == 4)) |=> !running);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !mode && !(wen && wdata == 32'd1 && w == 3)) |=> $stable(cnt));

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != 4'd0 && !(wen && w == 30)) |=> !tick);

  p_ien_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && w == 25) |=> ((ien & $past(wdata[19:16])) == $past(wdata[19:16])));

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_ev
      p_event_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[g] && !(wen && wdata == 32'd0 && w == (16 + g))) |=> evt[g]);
    end
  endgenerate
endmodule

bind cmp_timer cmp_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wen(wen), .wdata(wdata), .irq(irq),
  .cnt(cnt), .running(running), .mode(mode), .evt(evt), .ien(ien),
  .presc(presc), .tick(tick)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic clk = 1'b0, rst_n = 1'b0, wen = 1'b0, irq;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v, exp_v;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  cmp_timer i_cmp_timer (.clk(clk), .rst_n(rst_n), .addr(addr), .wen(wen),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] wmask(input int code);
    case (code)
      0: return 32'h0000_FFFF;
      1: return 32'h0000_00FF;
      2: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] ticks(input int m, input int p);
    return 32'((m + 1) >> p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; wen = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 0);
    rd(8'h60, v); check("R1 link", v, 0);
    rd(8'h64, v); check("R1 ien", v, 0);
    rd(8'h70, v); check("R1 mode", v, 0);
    rd(8'h74, v); check("R1 width", v, 0);
    rd(8'h78, v); check("R1 presc", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h80 + 8'(4*i), v); check("R1 cc", v, 0);
      rd(8'h40 + 8'(4*i), v); check("R1 evt", v, 0);
    end
    wr(8'h20, 1); rd(8'h80, v); check("R1 counter zero", v, 0);

    // R12 undefined and task addresses
    rd(8'h90, v); check("R12 undef read", v, 0);
    wr(8'h90, 32'hDEAD_BEEF); rd(8'h90, v); check("R12 undef write", v, 0);
    rd(8'h00, v); check("R12 task read", v, 0);

    // R8 enable set/clear
    wr(8'h64, 32'hFFFF_FFFF); rd(8'h64, v); check("R8 set", v, 32'h000F_0000);
    wr(8'h68, 32'h0005_0000); rd(8'h68, v); check("R8 clr", v, 32'h000A_0000);
    wr(8'h64, 32'h0001_0000); rd(8'h64, v); check("R8 set2", v, 32'h000B_0000);

    // R11 truncation on compare writes
    for (int k = 0; k < 8; k++) begin
      int code = int'($urandom % 4);
      logic [31:0] d = $urandom;
      int ch = int'($urandom % 4);
      wr(8'h74, 32'(code));
      wr(8'h80 + 8'(4*ch), d);
      rd(8'h80 + 8'(4*ch), v); check("R11 trunc", v, d & wmask(code));
    end

    // R2 R9 R10 counter mode with random width and counts
    wr(8'h70, 1);
    for (int k = 0; k < 6; k++) begin
      int code = int'($urandom % 4);
      int n = (k == 0) ? 300 : int'($urandom % 300);
      if (k == 0) code = 1;
      wr(8'h74, 32'(code));
      wr(8'h0C, 1);
      for (int j = 0; j < n; j++) wr(8'h08, 1);
      wr(8'h2C, 1);
      rd(8'h8C, v); check("R2 wrap count", v, 32'(n) & wmask(code));
      wr(8'h08, 2); wr(8'h2C, 1);
      rd(8'h8C, v); check("R9 count value 2", v, 32'(n) & wmask(code));
    end

    // R4 compare event, sticky, wrap
    wr(8'h74, 1);
    wr(8'h80, 5);
    wr(8'h0C, 1);
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(4*i), 0);
    for (int j = 0; j < 4; j++) wr(8'h08, 1);
    rd(8'h40, v); check("R4 before match", v, 0);
    wr(8'h08, 1);
    rd(8'h40, v); check("R4 match", v, 1);
    wr(8'h40, 7);
    rd(8'h40, v); check("R4 nonzero ignored", v, 1);
    wr(8'h40, 0);
    rd(8'h40, v); check("R4 cleared", v, 0);
    for (int j = 0; j < 256; j++) wr(8'h08, 1);
    rd(8'h40, v); check("R4 after wrap", v, 1);

    // R7 interrupt gating (enables bits 0,1,3)
    for (int i = 1; i < 4; i++) wr(8'h40 + 8'(4*i), 0);
    check("R7 irq on", {31'd0, irq}, 1);
    wr(8'h68, 32'h0001_0000);
    check("R7 irq masked", {31'd0, irq}, 0);
    wr(8'h64, 32'h0001_0000);
    check("R7 irq unmasked", {31'd0, irq}, 1);
    wr(8'h40, 0);
    check("R7 irq event gone", {31'd0, irq}, 0);

    // R5 link clear
    wr(8'h74, 0);
    wr(8'h60, 32'h1);
    wr(8'h80, 3);
    wr(8'h0C, 1);
    for (int j = 0; j < 3; j++) wr(8'h08, 1);
    wr(8'h28, 1); rd(8'h88, v); check("R5 cleared on match", v, 0);
    rd(8'h40, v); check("R5 event", v, 1);
    wr(8'h08, 1); wr(8'h08, 1);
    wr(8'h28, 1); rd(8'h88, v); check("R5 counts on", v, 2);

    // R3 R9 timer mode rates
    wr(8'h70, 0);
    wr(8'h60, 0);
    wr(8'h74, 3);
    for (int k = 0; k < 4; k++) begin
      int p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : 2;
      int m = 10 + int'($urandom % 40);
      wr(8'h78, 32'(p));
      wr(8'h0C, 1);
      wr(8'h00, 1);
      repeat (m) @(negedge clk);
      wr(8'h04, 1);
      wr(8'h24, 1);
      rd(8'h84, v); check("R3 prescaled count", v, ticks(m, p));
    end
    wr(8'h78, 13); rd(8'h78, v); check("R3 clamp", v, 9);
    wr(8'h78, 0);

    // R9 START with value 2, START in counter mode
    wr(8'h0C, 1);
    wr(8'h00, 2);
    repeat (5) @(negedge clk);
    wr(8'h24, 1); rd(8'h84, v); check("R9 start value 2", v, 0);
    wr(8'h70, 1); wr(8'h00, 1); wr(8'h70, 0);
    repeat (5) @(negedge clk);
    wr(8'h24, 1); rd(8'h84, v); check("R9 start counter mode", v, 0);

    // R9 SHUTDOWN halts
    wr(8'h00, 1);
    repeat (7) @(negedge clk);
    wr(8'h10, 1);
    wr(8'h24, 1); rd(8'h84, exp_v);
    repeat (10) @(negedge clk);
    wr(8'h24, 1); rd(8'h84, v); check("R9 shutdown holds", v, exp_v);
    check("R9 shutdown counted", exp_v, 8);

    // R6 link stop
    wr(8'h0C, 1);
    wr(8'h84, 4);
    wr(8'h44, 0);
    wr(8'h60, 32'h200);
    wr(8'h00, 1);
    repeat (20) @(negedge clk);
    wr(8'h28, 1); rd(8'h88, v); check("R6 stopped at match", v, 4);
    rd(8'h44, v); check("R6 event", v, 1);

    // R13 capture on a tick edge
    wr(8'h60, 0);
    wr(8'h0C, 1);
    wr(8'h00, 1);
    repeat (6) @(negedge clk);
    wr(8'h2C, 1);
    wr(8'h04, 1);
    rd(8'h8C, v); check("R13 capture post tick", v, 7);

    // R13 event clear on the match edge
    wr(8'h88, 7);
    wr(8'h48, 0);
    wr(8'h0C, 1);
    wr(8'h00, 1);
    repeat (6) @(negedge clk);
    wr(8'h48, 0);
    wr(8'h04, 1);
    rd(8'h48, v); check("R13 match beats clear", v, 1);
    wr(8'h48, 0);
    rd(8'h48, v); check("R13 later clear", v, 0);

    // R10 CLEAR while running
    wr(8'h0C, 1);
    wr(8'h00, 1);
    repeat (9) @(negedge clk);
    wr(8'h0C, 1);
    wr(8'h04, 1);
    wr(8'h24, 1); rd(8'h84, v); check("R10 clear restarts", v, 1);

    finished = 1;
    summary();
  end
endmodule